// File: doc/BRIEF.md
# Emulator Host Handshake Sequencer

This controller sits on the host side of an in-circuit emulator and runs the bring-up self-test of the target processor. It first holds the processor in reset for a fixed count of clock cycles, with emulation enabled. It then raises the emulator interrupt and waits for the processor to announce, through its emulator memory select, that it has entered emulator space. It answers that select with a bus request and waits for the grant. Under the grant it writes a test instruction (a NOP) into the byte-wide mailbox latches, one latch per cycle, and then drops the request.

The processor then executes the injected instruction and writes a test word back into the mailbox. The sequencer reads the latches one at a time, rebuilds the word and compares it with an expected constant. The result is a sticky pass or fail flag. A fail carries a code that names the stage that went wrong. Every wait has a bounded timeout, and a restart pulse starts the whole procedure again from the reset hold.

Top module: `emu_bringup_seq`

## Requirements
- R1: After `rst_n` is released, or after a `restart` pulse, `tgt_rst_n` stays low for exactly RST_HOLD (default 2000) rising clock edges and then goes high. While `rst_n` is low: `tgt_rst_n`=0, `emu_irq_n`=1, `breq_n`=1, `mbox_we`=0, `mbox_re`=0, `test_pass`=0, `test_fail`=0 and `fail_code`=0.
- R2: `tgt_emu_en` is high at all times, including during reset.
- R3: `emu_irq_n` goes low in the same cycle that `tgt_rst_n` goes high. It stays low until the memory select is accepted and is never low while `tgt_rst_n` is low.
- R4: `ems_n`, `bgrant_n` and `wb_rdy_n` each pass through a two-flop synchronizer. When `ems_n` falls while the interrupt is asserted, `breq_n` falls on the third rising edge after the change, and `emu_irq_n` returns high on that same edge.
- R5: On the third rising edge after `bgrant_n` falls, loading begins. On that edge and the next two, `mbox_we` is high, `mbox_sel` is the lane number (0, 1, 2 in turn), and `mbox_wdata` is bits [8*sel+7 : 8*sel] of NOP_WORD. `breq_n` stays low throughout, and no load ever happens with `breq_n` high.
- R6: `breq_n` returns high in the cycle right after the last lane is written. That is six cycles after the cycle in which `bgrant_n` was first driven low.
- R7: After `wb_rdy_n` falls and is synchronized, `mbox_re` is high for three consecutive cycles with `mbox_sel` = 0, 1, 2. The `mbox_rdata` value present in each of those cycles becomes bits [8*sel+7 : 8*sel] of the returned word. If the word equals CHECK_WORD, `test_pass` is set. Otherwise `test_fail` is set with `fail_code`=4.
- R8: Each wait (memory select, grant, write-back) lasts at most TIMEOUT cycles (default 4096). If the event is missing, `test_fail` rises TIMEOUT cycles after the wait began, with `fail_code` 1 (select), 2 (grant) or 3 (write-back). An event that is synchronized in the final counted cycle is still accepted.
- R9: `test_pass`, `test_fail` and `fail_code` hold their values, whatever the processor inputs do, until `restart`. A `restart` in any state clears them in the next cycle, drops any bus request and begins R1 again.
- R10: `test_pass` and `test_fail` are never high together, and `fail_code` is 0 whenever `test_fail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| restart | input | 1 | Synchronous request to restart the bring-up from the reset hold |
| tgt_rst_n | output | 1 | Reset to the target processor, active low |
| tgt_emu_en | output | 1 | Emulation enable to the target, held high |
| emu_irq_n | output | 1 | Emulator interrupt to the target, active low |
| ems_n | input | 1 | Emulator memory select from the target, active low |
| breq_n | output | 1 | Bus request to the target, active low |
| bgrant_n | input | 1 | Bus grant from the target, active low |
| wb_rdy_n | input | 1 | Target has written its test word into the mailbox, active low |
| mbox_we | output | 1 | Mailbox latch write strobe |
| mbox_re | output | 1 | Mailbox latch read strobe |
| mbox_sel | output | 2 | Mailbox lane selected for the current access |
| mbox_wdata | output | 8 | Byte written into the selected lane |
| mbox_rdata | input | 8 | Byte read from the selected lane |
| test_pass | output | 1 | Sticky self-test pass flag |
| test_fail | output | 1 | Sticky self-test fail flag |
| fail_code | output | 3 | Failing stage: 1 select timeout, 2 grant timeout, 3 write-back timeout, 4 compare mismatch |

## Verification
Two functions can meet in one cycle: a wait's timeout expiring and the awaited event arriving through the synchronizer. The bench provokes this on the grant wait. It counts cycles from the falling edge of `breq_n` and drives `bgrant_n` low at the latest point at which the synchronized grant still lands in the final counted cycle. That run must go on to a clean load and a pass. A second run drives the grant one cycle later, and it must end in `fail_code` 2 with no mailbox write at all.

// File: rtl/emu_seq_pkg.sv
package emu_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_IRQ   = 3'd1,
    ST_GRANT = 3'd2,
    ST_LOAD  = 3'd3,
    ST_WB    = 3'd4,
    ST_READ  = 3'd5,
    ST_PASS  = 3'd6,
    ST_FAIL  = 3'd7
  } seq_state_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_EMS_TO   = 3'd1,
    ERR_GRANT_TO = 3'd2,
    ERR_WB_TO    = 3'd3,
    ERR_MISMATCH = 3'd4
  } fail_code_e;

  // true for the states that wait on a processor event under a timeout
  function automatic logic is_wait_state(input seq_state_e s);
    return (s == ST_IRQ) || (s == ST_GRANT) || (s == ST_WB);
  endfunction

  // timeout code that belongs to a wait state
  function automatic fail_code_e stage_code(input seq_state_e s);
    case (s)
      ST_IRQ:   return ERR_EMS_TO;
      ST_GRANT: return ERR_GRANT_TO;
      ST_WB:    return ERR_WB_TO;
      default:  return ERR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/emu_sync.sv
module emu_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/emu_stage_timer.sv
module emu_stage_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/emu_mbox_lanes.sv
module emu_mbox_lanes #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  parameter logic [LANES*LANE_W-1:0] LOAD_WORD = '0,
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_step,
  input  logic              rd_step,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [IDX_W-1:0]  idx,
  output logic              last,
  output logic [LANE_W-1:0] wr_lane,
  output logic [WORD_W-1:0] rd_word
);

  logic [IDX_W-1:0]  idx_q;
  logic [LANE_W-1:0] lane_tab [LANES];

  assign last = (idx_q == IDX_W'(LANES - 1));
  assign idx  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idx_q <= '0;
    else if (clear)               idx_q <= '0;
    else if (wr_step || rd_step)  idx_q <= last ? '0 : idx_q + 1'b1;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] hold_q;
    logic              hit;

    assign hit         = rd_step && (idx_q == IDX_W'(i));
    assign lane_tab[i] = LOAD_WORD[i*LANE_W +: LANE_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hold_q <= '0;
      else if (hit) hold_q <= rd_lane;
    end

    assign rd_word[i*LANE_W +: LANE_W] = hit ? rd_lane : hold_q;
  end

  assign wr_lane = lane_tab[idx_q];

endmodule

// File: rtl/emu_bringup_seq.sv
module emu_bringup_seq
  import emu_seq_pkg::*;
#(
  parameter int RST_HOLD = 2000,
  parameter int TIMEOUT  = 4096,
  parameter int LANES    = 3,
  parameter int LANE_W   = 8,
  parameter logic [LANES*LANE_W-1:0] NOP_WORD   = '0,
  parameter logic [LANES*LANE_W-1:0] CHECK_WORD = 24'hC3_5A_A5,
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic              tgt_rst_n,
  output logic              tgt_emu_en,
  output logic              emu_irq_n,
  input  logic              ems_n,
  output logic              breq_n,
  input  logic              bgrant_n,
  input  logic              wb_rdy_n,
  output logic              mbox_we,
  output logic              mbox_re,
  output logic [IDX_W-1:0]  mbox_sel,
  output logic [LANE_W-1:0] mbox_wdata,
  input  logic [LANE_W-1:0] mbox_rdata,
  output logic              test_pass,
  output logic              test_fail,
  output logic [2:0]        fail_code
);

  seq_state_e st_q, st_d;
  fail_code_e code_q, code_d;
  logic       code_set;

  // named internal events, also observed by the checker
  logic [2:0]        sync_n;
  logic              ems_act, bg_act, wb_act;
  logic              in_irq, in_grant, in_load, in_wb, in_read;
  logic              stage_event;
  logic              stage_expire;
  logic              timed_out;
  logic              hold_done;
  logic              step_clear;
  logic              lane_last;
  logic              word_match;
  logic [WORD_W-1:0] back_word;

  emu_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({wb_rdy_n, bgrant_n, ems_n}),
    .q     (sync_n)
  );

  assign ems_act = ~sync_n[0];
  assign bg_act  = ~sync_n[1];
  assign wb_act  = ~sync_n[2];

  assign in_irq   = (st_q == ST_IRQ);
  assign in_grant = (st_q == ST_GRANT);
  assign in_load  = (st_q == ST_LOAD);
  assign in_wb    = (st_q == ST_WB);
  assign in_read  = (st_q == ST_READ);

  assign stage_event = (in_irq && ems_act) || (in_grant && bg_act) || (in_wb && wb_act);
  assign timed_out   = stage_expire && !stage_event;
  assign step_clear  = restart || (st_d != st_q);

  emu_stage_timer #(.LIMIT(RST_HOLD)) u_hold_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (step_clear),
    .run    (st_q == ST_HOLD),
    .expire (hold_done)
  );

  emu_stage_timer #(.LIMIT(TIMEOUT)) u_wait_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (step_clear),
    .run    (is_wait_state(st_q)),
    .expire (stage_expire)
  );

  emu_mbox_lanes #(
    .LANES     (LANES),
    .LANE_W    (LANE_W),
    .LOAD_WORD (NOP_WORD)
  ) u_mbox (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (step_clear),
    .wr_step (in_load),
    .rd_step (in_read),
    .rd_lane (mbox_rdata),
    .idx     (mbox_sel),
    .last    (lane_last),
    .wr_lane (mbox_wdata),
    .rd_word (back_word)
  );

  assign word_match = (back_word == CHECK_WORD);

  always_comb begin
    st_d     = st_q;
    code_d   = ERR_NONE;
    code_set = 1'b0;
    case (st_q)
      ST_HOLD:  if (hold_done) st_d = ST_IRQ;
      ST_IRQ, ST_GRANT, ST_WB: begin
        if (stage_event) begin
          st_d = (st_q == ST_IRQ) ? ST_GRANT : (st_q == ST_GRANT) ? ST_LOAD : ST_READ;
        end else if (timed_out) begin
          st_d     = ST_FAIL;
          code_d   = stage_code(st_q);
          code_set = 1'b1;
        end
      end
      ST_LOAD:  if (lane_last) st_d = ST_WB;
      ST_READ: begin
        if (lane_last) begin
          if (word_match) begin
            st_d = ST_PASS;
          end else begin
            st_d     = ST_FAIL;
            code_d   = ERR_MISMATCH;
            code_set = 1'b1;
          end
        end
      end
      default: st_d = st_q;
    endcase
    if (restart) begin
      st_d     = ST_HOLD;
      code_set = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOLD;
      code_q <= ERR_NONE;
    end else begin
      st_q <= st_d;
      if (restart)       code_q <= ERR_NONE;
      else if (code_set) code_q <= code_d;
    end
  end

  assign tgt_rst_n  = (st_q != ST_HOLD);
  assign tgt_emu_en = 1'b1;
  assign emu_irq_n  = ~in_irq;
  assign breq_n     = ~(in_grant || in_load);
  assign mbox_we    = in_load;
  assign mbox_re    = in_read;
  assign test_pass  = (st_q == ST_PASS);
  assign test_fail  = (st_q == ST_FAIL);
  assign fail_code  = code_q;

endmodule

// File: rtl/emu_bringup_seq_chk.sv
module emu_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       restart,
  input logic       tgt_rst_n,
  input logic       emu_irq_n,
  input logic       breq_n,
  input logic       mbox_we,
  input logic       test_pass,
  input logic       test_fail,
  input logic [2:0] fail_code,
  input logic       in_irq,
  input logic       in_grant,
  input logic       ems_act,
  input logic       bg_act,
  input logic       lane_last,
  input logic       timed_out
);

  // R3
  irq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> emu_irq_n);

  // R4
  ems_to_breq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_irq && ems_act && !restart) |=> (!breq_n && emu_irq_n));

  // R5
  load_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_we |-> !breq_n);

  // R6
  breq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_we && lane_last && !restart) |=> breq_n);

  // R8
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !restart) |=> (test_fail && fail_code != 3'd0));

  // R8
  grant_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_grant && bg_act && !restart) |=> mbox_we);

  // R9
  pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_pass && !restart) |=> test_pass);

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_fail && !restart) |=> (test_fail && $stable(fail_code)));

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!test_pass && !test_fail && !tgt_rst_n && breq_n));

  // R10
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_pass && test_fail));

  // R10
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_fail |-> (fail_code == 3'd0));

endmodule

bind emu_bringup_seq emu_bringup_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .tgt_rst_n (tgt_rst_n),
  .emu_irq_n (emu_irq_n),
  .breq_n    (breq_n),
  .mbox_we   (mbox_we),
  .test_pass (test_pass),
  .test_fail (test_fail),
  .fail_code (fail_code),
  .in_irq    (in_irq),
  .in_grant  (in_grant),
  .ems_act   (ems_act),
  .bg_act    (bg_act),
  .lane_last (lane_last),
  .timed_out (timed_out)
);

// File: tb/emu_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module emu_bringup_seq_tb_top;

  localparam int          HOLD_N = 2000;
  localparam int          TO_N   = 4096;
  localparam logic [23:0] NOP_V  = 24'hA1B2C3;
  localparam logic [23:0] CHK_V  = 24'h5AC3A5;

  logic       clk = 1'b0;
  logic       rst_n, restart;
  logic       tgt_rst_n, tgt_emu_en, emu_irq_n, breq_n;
  logic       ems_n, bgrant_n, wb_rdy_n;
  logic       mbox_we, mbox_re;
  logic [1:0] mbox_sel;
  logic [7:0] mbox_wdata, mbox_rdata;
  logic       test_pass, test_fail;
  logic [2:0] fail_code;
  logic [23:0] back_v;
  logic [23:0] shifted;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct { logic [1:0] sel; logic [7:0] data; } lane_t;
  lane_t      wr_q[$];
  logic [1:0] rd_q[$];

  always #2.5 clk = ~clk;

  // processor side of the mailbox: lane sel returns byte sel of back_v
  assign shifted    = back_v >> (mbox_sel * 8);
  assign mbox_rdata = shifted[7:0];

  emu_bringup_seq #(
    .RST_HOLD   (HOLD_N),
    .TIMEOUT    (TO_N),
    .NOP_WORD   (NOP_V),
    .CHECK_WORD (CHK_V)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .tgt_rst_n  (tgt_rst_n),
    .tgt_emu_en (tgt_emu_en),
    .emu_irq_n  (emu_irq_n),
    .ems_n      (ems_n),
    .breq_n     (breq_n),
    .bgrant_n   (bgrant_n),
    .wb_rdy_n   (wb_rdy_n),
    .mbox_we    (mbox_we),
    .mbox_re    (mbox_re),
    .mbox_sel   (mbox_sel),
    .mbox_wdata (mbox_wdata),
    .mbox_rdata (mbox_rdata),
    .test_pass  (test_pass),
    .test_fail  (test_fail),
    .fail_code  (fail_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // monitor: pops expected lane accesses as the design produces them
  always @(negedge clk) begin
    if (rst_n && mbox_we) begin
      if (wr_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected mailbox load", mbox_sel, 0);
      end else begin
        lane_t e;
        e = wr_q.pop_front();
        chk(mbox_sel == e.sel, "R5", "load lane", mbox_sel, e.sel);
        chk(mbox_wdata == e.data, "R5", "load byte", mbox_wdata, e.data);
        chk(breq_n == 1'b0, "R5", "load without request", breq_n, 0);
      end
    end
    if (rst_n && mbox_re) begin
      if (rd_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected mailbox read", mbox_sel, 0);
      end else begin
        logic [1:0] s;
        s = rd_q.pop_front();
        chk(mbox_sel == s, "R7", "read lane", mbox_sel, s);
      end
    end
  end

  task automatic proc_idle();
    ems_n = 1'b1; bgrant_n = 1'b1; wb_rdy_n = 1'b1;
  endtask

  task automatic count_hold(input string req);
    int n = 0;
    while (!tgt_rst_n && n < HOLD_N + 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == HOLD_N, req, "reset hold length", n, HOLD_N);
    chk(emu_irq_n == 1'b0, "R3", "irq at reset release", emu_irq_n, 0);
  endtask

  task automatic restart_seq();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    proc_idle();
    chk(!test_pass && !test_fail && fail_code == 0, "R9", "status cleared by restart",
        {test_pass, test_fail, fail_code}, 0);
    chk(breq_n == 1'b1, "R9", "request dropped by restart", breq_n, 1);
    count_hold("R1");
  endtask

  task automatic ems_phase(input int dly);
    repeat (dly) @(negedge clk);
    ems_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(breq_n == 1'b1, "R4", "request before sync delay", breq_n, 1);
    @(posedge clk);
    @(negedge clk);
    chk(breq_n == 1'b0, "R4", "request after select", breq_n, 0);
    chk(emu_irq_n == 1'b1, "R3", "irq released on select", emu_irq_n, 1);
  endtask

  task automatic grant_phase(input int dly);
    int n = 0;
    repeat (dly) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      lane_t e;
      e.sel  = 2'(i);
      e.data = 8'((NOP_V >> (8 * i)) & 24'hFF);
      wr_q.push_back(e);
    end
    bgrant_n = 1'b0;
    while (breq_n == 1'b0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 6, "R6", "request release cycle", n, 6);
    chk(wr_q.size() == 0, "R5", "lanes left unloaded", wr_q.size(), 0);
    ems_n = 1'b1;
    bgrant_n = 1'b1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!test_pass && !test_fail && n < TO_N + 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wb_phase(input logic [23:0] word, input bit exp_pass);
    int n;
    back_v = word;
    for (int i = 0; i < 3; i++) rd_q.push_back(2'(i));
    wb_rdy_n = 1'b0;
    wait_done(n);
    chk(test_pass == exp_pass, "R7", "pass flag", test_pass, exp_pass);
    chk(test_fail == !exp_pass, "R7", "fail flag", test_fail, !exp_pass);
    chk(fail_code == (exp_pass ? 3'd0 : 3'd4), "R7", "mismatch code", fail_code,
        exp_pass ? 0 : 4);
    chk(rd_q.size() == 0, "R7", "lanes left unread", rd_q.size(), 0);
    wb_rdy_n = 1'b1;
  endtask

  task automatic expect_timeout(input logic [2:0] code, input string what);
    int n;
    wait_done(n);
    chk(n == TO_N, "R8", {what, " timeout length"}, n, TO_N);
    chk(test_fail && fail_code == code, "R8", {what, " timeout code"}, fail_code, code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; back_v = '0;
    proc_idle();
    repeat (4) @(negedge clk);
    // R1 R2 R10: reset state
    chk(tgt_rst_n == 0 && emu_irq_n == 1 && breq_n == 1, "R1", "reset outputs",
        {tgt_rst_n, emu_irq_n, breq_n}, 3'b011);
    chk(!mbox_we && !mbox_re, "R1", "no mailbox access in reset", {mbox_we, mbox_re}, 0);
    chk(tgt_emu_en == 1'b1, "R2", "emulation enable in reset", tgt_emu_en, 1);
    chk(!test_pass && !test_fail && fail_code == 0, "R10", "status in reset",
        {test_pass, test_fail, fail_code}, 0);
    rst_n = 1'b1;
    #1;
    count_hold("R1");
    chk(tgt_emu_en == 1'b1, "R2", "emulation enable after release", tgt_emu_en, 1);

    // normal bring-up ending in pass
    ems_phase(5);
    grant_phase(2);
    wb_phase(CHK_V, 1'b1);

    // R9: processor activity after pass changes nothing
    ems_n = 1'b0; bgrant_n = 1'b0; wb_rdy_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(test_pass && !test_fail && fail_code == 0, "R9", "pass is sticky",
        {test_pass, test_fail, fail_code}, 5'b10000);
    chk(breq_n == 1'b1, "R9", "no request after pass", breq_n, 1);

    // compare mismatch in the top lane
    restart_seq();
    ems_phase(0);
    grant_phase(0);
    wb_phase(CHK_V ^ 24'h800000, 1'b0);

    // memory select never arrives
    restart_seq();
    expect_timeout(3'd1, "select");

    // grant never arrives
    restart_seq();
    ems_phase(1);
    expect_timeout(3'd2, "grant");

    // grant synchronized in the final counted cycle: accepted
    restart_seq();
    ems_phase(0);
    repeat (TO_N - 3) @(negedge clk);
    grant_phase(0);
    wb_phase(CHK_V, 1'b1);

    // grant one cycle too late: R8 timeout, no load
    restart_seq();
    ems_phase(0);
    repeat (TO_N - 2) @(negedge clk);
    bgrant_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(test_fail && fail_code == 3'd2, "R8", "late grant code", fail_code, 2);
    proc_idle();

    // write-back never arrives
    restart_seq();
    ems_phase(0);
    grant_phase(0);
    expect_timeout(3'd3, "write-back");

    // restart while waiting for the grant, then a full pass
    restart_seq();
    ems_phase(0);
    repeat (10) @(negedge clk);
    restart_seq();
    ems_phase(0);
    grant_phase(1);
    wb_phase(CHK_V, 1'b1);

    summary();
    $finish;
  end

endmodule